// File: doc/BRIEF.md
# Speculative Integer Register Store with Bulk Rollback

This block keeps the integer register state of an out-of-order core in one structure of three groups. Sixteen 64-bit committed registers hold the architectural state. Sixteen speculative copies hold the newest in-flight values of those same registers. Eight scratch registers are reserved for microcode sequences. In-flight instructions read their sources from the speculative copies and write their results back to them. Retiring instructions update the committed copies.

When a branch was mispredicted or an exception was raised, one strobe copies every committed register over its speculative copy in a single clock. Recovery therefore needs no walk of a rename map. The scratch group does not take part in recovery.

Two combinational read ports see a flat 5-bit register space. Each read returns a value written by a same-cycle speculative or scratch write without waiting a cycle.

Top module: `spec_reg_store`

## Requirements
- R1: After reset all 40 registers hold zero, so every read address returns zero.
- R2: On either read port, address 0 to 15 selects the speculative copy of that register, address 16 to 23 selects scratch register (address minus 16), and address 24 to 31 returns zero.
- R3: A speculative write with no rollback in the same cycle sets the speculative copy of the addressed register from the next cycle onward. It leaves the committed copy unchanged.
- R4: A commit write changes only the committed copy of the addressed register. Reads keep returning the speculative copy until that copy is restored by a rollback.
- R5: A rollback replaces all 16 speculative copies with the committed values in one clock. Reads in the following cycle return the restored values.
- R6: A speculative write issued in the same cycle as a rollback is discarded. The addressed register holds its committed value afterwards.
- R7: A commit write issued in the same cycle as a rollback is stored in both copies. The next read of that register returns the newly committed value.
- R8: A read whose address matches a same-cycle speculative write (with no rollback) returns the write data in that cycle. A read whose address matches a same-cycle scratch write also returns the write data in that cycle.
- R9: Scratch registers change only through the scratch write path. Rollback, speculative writes and commit writes leave them unchanged.
- R10: During a rollback cycle, reads of addresses 0 to 15 return the speculative contents held before the restore, with no bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_a | input | 5 | Read port A address |
| rd_data_a | output | 64 | Read port A data (combinational) |
| rd_addr_b | input | 5 | Read port B address |
| rd_data_b | output | 64 | Read port B data (combinational) |
| spec_we | input | 1 | Speculative write enable |
| spec_addr | input | 4 | Speculative write register index |
| spec_data | input | 64 | Speculative write data |
| cmt_we | input | 1 | Commit write enable |
| cmt_addr | input | 4 | Commit write register index |
| cmt_data | input | 64 | Commit write data |
| scr_we | input | 1 | Scratch write enable |
| scr_addr | input | 3 | Scratch register index |
| scr_data | input | 64 | Scratch write data |
| rollback | input | 1 | Restore all speculative copies from committed copies |

## Verification
Directed sequences first commit a value and confirm that the speculative view does not change until a rollback exposes it. This separates the two copies. Further directed cases put a rollback in the same cycle as a speculative write or a commit write, which pins down the priority between them. Long random runs then mix all four write paths with reads biased toward the register being written. These runs separate the same-cycle bypass from registered data, the scratch region from the speculative region and from the empty top of the address space, and show that scratch contents survive rollbacks. A cycle-accurate reference model in the bench is compared on both read ports in every cycle.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int DATA_W = 64;
    localparam int ARCH_N = 16;
    localparam int SCR_N  = 8;

    typedef enum logic [1:0] {
        RGN_FUT  = 2'd0,
        RGN_SCR  = 2'd1,
        RGN_NONE = 2'd2
    } rgn_e;
endpackage

// File: rtl/sreg_read_port.sv
module sreg_read_port
    import sreg_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AN = ARCH_N,
    parameter int SN = SCR_N,
    parameter int AW = $clog2(AN + SN)
) (
    input  logic [AW-1:0]           rd_addr,
    input  logic [AN-1:0][W-1:0]    fut,
    input  logic [SN-1:0][W-1:0]    scr,
    input  logic                    byp_fut_en,
    input  logic [$clog2(AN)-1:0]   byp_fut_idx,
    input  logic [W-1:0]            byp_fut_data,
    input  logic                    byp_scr_en,
    input  logic [$clog2(SN)-1:0]   byp_scr_idx,
    input  logic [W-1:0]            byp_scr_data,
    output logic [W-1:0]            rd_data
);
    localparam int FI = $clog2(AN);
    localparam int SI = $clog2(SN);

    rgn_e          rgn;
    logic [FI-1:0] fut_idx;
    logic [AW-1:0] scr_off;
    logic [SI-1:0] scr_idx;

    always_comb begin
        fut_idx = rd_addr[FI-1:0];
        scr_off = rd_addr - AW'(AN);
        scr_idx = scr_off[SI-1:0];
        if (rd_addr < AW'(AN))
            rgn = RGN_FUT;
        else if (rd_addr < AW'(AN + SN))
            rgn = RGN_SCR;
        else
            rgn = RGN_NONE;

        unique case (rgn)
            RGN_FUT:
                rd_data = (byp_fut_en && byp_fut_idx == fut_idx) ? byp_fut_data : fut[fut_idx];
            RGN_SCR:
                rd_data = (byp_scr_en && byp_scr_idx == scr_idx) ? byp_scr_data : scr[scr_idx];
            default:
                rd_data = '0;
        endcase
    end
endmodule

// File: rtl/sreg_state.sv
module sreg_state
    import sreg_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AN = ARCH_N,
    parameter int SN = SCR_N
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spec_we,
    input  logic [$clog2(AN)-1:0]   spec_idx,
    input  logic [W-1:0]            spec_data,
    input  logic                    cmt_we,
    input  logic [$clog2(AN)-1:0]   cmt_idx,
    input  logic [W-1:0]            cmt_data,
    input  logic                    scr_we,
    input  logic [$clog2(SN)-1:0]   scr_idx,
    input  logic [W-1:0]            scr_data,
    input  logic                    rollback,
    output logic [AN-1:0][W-1:0]    arch_o,
    output logic [AN-1:0][W-1:0]    fut_o,
    output logic [SN-1:0][W-1:0]    scr_o
);
    typedef struct packed {
        logic [AN-1:0][W-1:0] arch;
        logic [AN-1:0][W-1:0] fut;
        logic [SN-1:0][W-1:0] scr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmt_we)
            st_d.arch[cmt_idx] = cmt_data;
        if (rollback) begin
            st_d.fut = st_q.arch;
            if (cmt_we)
                st_d.fut[cmt_idx] = cmt_data;
        end else if (spec_we) begin
            st_d.fut[spec_idx] = spec_data;
        end
        if (scr_we)
            st_d.scr[scr_idx] = scr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign arch_o = st_q.arch;
    assign fut_o  = st_q.fut;
    assign scr_o  = st_q.scr;
endmodule

// File: rtl/spec_reg_store.sv
module spec_reg_store
    import sreg_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AN = ARCH_N,
    parameter int SN = SCR_N,
    parameter int AW = $clog2(AN + SN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           rd_addr_a,
    output logic [W-1:0]            rd_data_a,
    input  logic [AW-1:0]           rd_addr_b,
    output logic [W-1:0]            rd_data_b,
    input  logic                    spec_we,
    input  logic [$clog2(AN)-1:0]   spec_addr,
    input  logic [W-1:0]            spec_data,
    input  logic                    cmt_we,
    input  logic [$clog2(AN)-1:0]   cmt_addr,
    input  logic [W-1:0]            cmt_data,
    input  logic                    scr_we,
    input  logic [$clog2(SN)-1:0]   scr_addr,
    input  logic [W-1:0]            scr_data,
    input  logic                    rollback
);
    localparam int NRD = 2;

    logic [AN-1:0][W-1:0] arch_q;
    logic [AN-1:0][W-1:0] fut_q;
    logic [SN-1:0][W-1:0] scr_q;
    logic                 fut_byp_en;
    logic [AW-1:0]        rd_addr_v [NRD];
    logic [W-1:0]         rd_data_v [NRD];

    sreg_state #(.W(W), .AN(AN), .SN(SN)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .spec_we   (spec_we),
        .spec_idx  (spec_addr),
        .spec_data (spec_data),
        .cmt_we    (cmt_we),
        .cmt_idx   (cmt_addr),
        .cmt_data  (cmt_data),
        .scr_we    (scr_we),
        .scr_idx   (scr_addr),
        .scr_data  (scr_data),
        .rollback  (rollback),
        .arch_o    (arch_q),
        .fut_o     (fut_q),
        .scr_o     (scr_q)
    );

    // a speculative write squashed by rollback must not be forwarded
    assign fut_byp_en = spec_we & ~rollback;

    assign rd_addr_v[0] = rd_addr_a;
    assign rd_addr_v[1] = rd_addr_b;
    assign rd_data_a    = rd_data_v[0];
    assign rd_data_b    = rd_data_v[1];

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        sreg_read_port #(.W(W), .AN(AN), .SN(SN), .AW(AW)) u_rd (
            .rd_addr      (rd_addr_v[p]),
            .fut          (fut_q),
            .scr          (scr_q),
            .byp_fut_en   (fut_byp_en),
            .byp_fut_idx  (spec_addr),
            .byp_fut_data (spec_data),
            .byp_scr_en   (scr_we),
            .byp_scr_idx  (scr_addr),
            .byp_scr_data (scr_data),
            .rd_data      (rd_data_v[p])
        );
    end
endmodule

// File: rtl/sreg_checker.sv
module sreg_checker #(
    parameter int W  = 64,
    parameter int AN = 16,
    parameter int SN = 8,
    parameter int AW = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rollback,
    input logic                  spec_we,
    input logic [$clog2(AN)-1:0] spec_addr,
    input logic [W-1:0]          spec_data,
    input logic                  cmt_we,
    input logic [$clog2(AN)-1:0] cmt_addr,
    input logic [W-1:0]          cmt_data,
    input logic                  scr_we,
    input logic [AW-1:0]         rd_addr_a,
    input logic [W-1:0]          rd_data_a,
    input logic [AN-1:0][W-1:0]  arch_q,
    input logic [AN-1:0][W-1:0]  fut_q,
    input logic [SN-1:0][W-1:0]  scr_q
);
    assert_hole_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a >= AW'(AN + SN)) |-> (rd_data_a == '0));

    assert_spec_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_we && !rollback) |=> (fut_q[$past(spec_addr)] == $past(spec_data)));

    assert_arch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cmt_we |=> $stable(arch_q));

    assert_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rollback && !cmt_we) |=> (fut_q == $past(arch_q)));

    assert_squash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rollback && spec_we && !(cmt_we && cmt_addr == spec_addr))
        |=> (fut_q[$past(spec_addr)] == $past(arch_q[spec_addr])));

    assert_rb_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rollback && cmt_we) |=> (fut_q[$past(cmt_addr)] == $past(cmt_data)));

    assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_we && !rollback && rd_addr_a == AW'(spec_addr)) |-> (rd_data_a == spec_data));

    assert_scr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !scr_we |=> $stable(scr_q));
endmodule

bind spec_reg_store sreg_checker #(.W(W), .AN(AN), .SN(SN), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rollback  (rollback),
    .spec_we   (spec_we),
    .spec_addr (spec_addr),
    .spec_data (spec_data),
    .cmt_we    (cmt_we),
    .cmt_addr  (cmt_addr),
    .cmt_data  (cmt_data),
    .scr_we    (scr_we),
    .rd_addr_a (rd_addr_a),
    .rd_data_a (rd_data_a),
    .arch_q    (arch_q),
    .fut_q     (fut_q),
    .scr_q     (scr_q)
);

// File: tb/test_spec_reg_store.sv
module test_spec_reg_store;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_addr_a = '0, rd_addr_b = '0;
    logic [63:0] rd_data_a, rd_data_b;
    logic        spec_we = 1'b0, cmt_we = 1'b0, scr_we = 1'b0, rollback = 1'b0;
    logic [3:0]  spec_addr = '0, cmt_addr = '0;
    logic [2:0]  scr_addr = '0;
    logic [63:0] spec_data = '0, cmt_data = '0, scr_data = '0;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] m_arch [16];
    logic [63:0] m_fut  [16];
    logic [63:0] m_scr  [8];
    bit prev_rb = 0, prev_rb_cmt = 0, prev_rb_spec = 0, prev_cmt = 0;

    always #4 clk = ~clk;

    spec_reg_store i_spec_reg_store (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .spec_we(spec_we), .spec_addr(spec_addr), .spec_data(spec_data),
        .cmt_we(cmt_we), .cmt_addr(cmt_addr), .cmt_data(cmt_data),
        .scr_we(scr_we), .scr_addr(scr_addr), .scr_data(scr_data),
        .rollback(rollback)
    );

    function automatic logic [63:0] exp_rd(logic [4:0] a);
        if (a < 16) begin
            if (spec_we && !rollback && a[3:0] == spec_addr) return spec_data;
            return m_fut[a[3:0]];
        end else if (a < 24) begin
            logic [4:0] off = a - 5'd16;
            if (scr_we && off[2:0] == scr_addr) return scr_data;
            return m_scr[off[2:0]];
        end
        return '0;
    endfunction

    function automatic string auto_tag(logic [4:0] a);
        logic [4:0] off = a - 5'd16;
        if (rollback && a < 16) return "R10";
        if (a < 16 && spec_we && !rollback && a[3:0] == spec_addr) return "R8";
        if (a >= 16 && a < 24 && scr_we && off[2:0] == scr_addr) return "R8";
        if (prev_rb_cmt) return "R7";
        if (prev_rb_spec) return "R6";
        if (prev_rb) return "R5";
        if (a >= 24) return "R2";
        if (a >= 16) return "R9";
        if (prev_cmt) return "R4";
        return "R3";
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // entered just after a negedge with inputs applied
    task automatic cyc(string tag);
        #2;
        chk((tag == "") ? auto_tag(rd_addr_a) : tag, rd_data_a, exp_rd(rd_addr_a));
        chk((tag == "") ? auto_tag(rd_addr_b) : tag, rd_data_b, exp_rd(rd_addr_b));
        @(posedge clk);
        if (rollback) begin
            for (int i = 0; i < 16; i++) m_fut[i] = m_arch[i];
            if (cmt_we) m_fut[cmt_addr] = cmt_data;
        end else if (spec_we) begin
            m_fut[spec_addr] = spec_data;
        end
        if (cmt_we) m_arch[cmt_addr] = cmt_data;
        if (scr_we) m_scr[scr_addr] = scr_data;
        prev_rb      = rollback;
        prev_rb_cmt  = rollback && cmt_we;
        prev_rb_spec = rollback && spec_we;
        prev_cmt     = cmt_we;
        @(negedge clk);
    endtask

    task automatic idle();
        spec_we = 0; cmt_we = 0; scr_we = 0; rollback = 0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin m_arch[i] = '0; m_fut[i] = '0; end
        for (int i = 0; i < 8; i++) m_scr[i] = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every address reads zero after reset
        for (int a = 0; a < 32; a += 2) begin
            rd_addr_a = 5'(a); rd_addr_b = 5'(a + 1);
            cyc("R1");
        end

        // R4: commit leaves speculative view unchanged until rollback
        idle(); cmt_we = 1; cmt_addr = 4'd3; cmt_data = 64'hA5A5_0000_1111_2222;
        rd_addr_a = 5'd3; rd_addr_b = 5'd4;
        cyc("R4");
        idle(); cyc("R4");
        rollback = 1; cyc("R10");
        idle(); cyc("R5");

        // R3 and R8: speculative write, bypass, then registered
        spec_we = 1; spec_addr = 4'd9; spec_data = 64'h0123_4567_89AB_CDEF;
        rd_addr_a = 5'd9; rd_addr_b = 5'd10;
        cyc("R8");
        idle(); rd_addr_b = 5'd9; cyc("R3");

        // R6: speculative write squashed by rollback
        spec_we = 1; spec_addr = 4'd9; spec_data = 64'hDEAD_BEEF_0000_0001; rollback = 1;
        cyc("R10");
        idle(); cyc("R6");

        // R7: commit in the rollback cycle reaches the speculative copy
        cmt_we = 1; cmt_addr = 4'd7; cmt_data = 64'h7777_0000_7777_0000; rollback = 1;
        rd_addr_a = 5'd7; rd_addr_b = 5'd3;
        cyc("R10");
        idle(); cyc("R7");

        // R9: scratch write, then rollback leaves it alone
        scr_we = 1; scr_addr = 3'd5; scr_data = 64'h5C5C_5C5C_5C5C_5C5C;
        rd_addr_a = 5'd21; rd_addr_b = 5'd26;
        cyc("R8");
        idle(); rollback = 1; cyc("R9");
        idle(); cyc("R9");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            spec_we   = ($urandom % 2) == 0;
            spec_addr = 4'($urandom);
            spec_data = {$urandom, $urandom};
            cmt_we    = ($urandom % 3) == 0;
            cmt_addr  = ($urandom % 2) ? spec_addr : 4'($urandom);
            cmt_data  = {$urandom, $urandom};
            scr_we    = ($urandom % 4) == 0;
            scr_addr  = 3'($urandom);
            scr_data  = {$urandom, $urandom};
            rollback  = ($urandom % 8) == 0;
            rd_addr_a = ($urandom % 2) ? {1'b0, spec_addr} : 5'($urandom);
            rd_addr_b = ($urandom % 2) ? {2'b10, scr_addr} : 5'($urandom);
            cyc("");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule